// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block holds stores after they have committed and before the data cache has absorbed them. A store counts as retired once it is accepted here. Stores to the same 32-byte cache line are folded into one line-sized entry. One cache write can then carry the effect of several stores. The entries empty toward the cache one at a time, oldest first, over a valid/acknowledge drain port. An entry stays in place until the cache acknowledges it.

Loads probe the buffer by line while stores are still waiting. The probe returns a per-byte hit mask and the forwarded bytes, so the caller can take those bytes from here and the rest from the cache. Where more than one store has written a byte, the youngest value wins. When every entry is taken, a store that needs a new entry is refused, and the commit stage stalls. A store that can fold into an existing entry is still taken.

The entry that is currently offered on the drain port is frozen. A store to that entry's line starts a fresh entry behind it instead of changing data that is already on its way to the cache.

Top module: `stwc_buffer`

## Requirements
- R1: A store is taken on a clock edge where `st_valid` and `st_ready` are both high. Its data lands in the line named by `st_addr[31:5]`, at 8-byte word `st_addr[4:3]`. Store byte j (bits 8j+7..8j of `st_data`, enabled by `st_be[j]`) goes to line byte 8*word+j. A store with all enables low is taken and changes nothing.
- R2: A store to a line that already has an entry, other than the one on the drain port, merges into that entry. Only its enabled bytes are overwritten, the other bytes keep their values, and no new entry is used.
- R3: When several stores write the same byte, the drain data and the load forwarding both show the value of the youngest of them. This holds both within one entry and across entries.
- R4: Whenever the buffer holds an entry, `dr_valid` is high and the drain port shows the oldest entry. `dr_line` is its line number, `dr_mask` has bit b set for each written byte b, and `dr_data` carries byte b at bits 8b+7..8b. Bytes that were never written read as zero. Entries leave in the order they were allocated.
- R5: An entry is released only on a clock edge with `dr_ack` high. Until then `dr_valid`, `dr_line`, `dr_data` and `dr_mask` hold steady. After the last entry is released, `dr_valid` goes low.
- R6: A store to the line whose entry is on the drain port allocates a new entry. The drained entry's data and mask are not changed.
- R7: With all 8 entries occupied, `st_ready` is low for a store that would need a new entry, and such a store is not taken. A store that can merge under R2 keeps `st_ready` high. `st_ready` depends combinationally on the offered address.
- R8: A lookup with `ld_valid` high at a clock edge answers on the next cycle with `ld_resp_valid` high. `ld_hit` bit b is set if any entry for line `ld_addr[31:5]` holds byte b. `ld_data` carries the youngest such byte value, and zero where `ld_hit` is clear. The answer covers stores taken at earlier edges. Without a lookup, `ld_resp_valid` and `ld_hit` are zero.
- R9: After reset the buffer is empty, `dr_valid` is low, `st_ready` is high and a lookup reports no hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Committed store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 32 | Store byte address (low 3 bits ignored) |
| st_data | input | 64 | Store data word |
| st_be | input | 8 | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load byte address (line part used) |
| ld_resp_valid | output | 1 | Lookup answer valid |
| ld_hit | output | 32 | Per-byte forwarding mask |
| ld_data | output | 256 | Forwarded line bytes |
| dr_valid | output | 1 | Oldest entry offered to the cache |
| dr_line | output | 27 | Line number of offered entry |
| dr_data | output | 256 | Line data of offered entry |
| dr_mask | output | 32 | Written-byte mask of offered entry |
| dr_ack | input | 1 | Cache has written the offered entry |

## Verification
On every cycle the assertions check these rules: the drain port holds steady while it is not acknowledged, a refused store happens only with the buffer full, the occupancy never exceeds the depth, any offered entry carries at least one written byte, and the lookup answer comes exactly one cycle after its request. What only the directed scenarios can show are the byte-level results. These are how merged and overlapping stores combine, the youngest-wins priority across entries that share a line, the split between the locked entry and a new one on the same line, and the oldest-first drain order before and after the full stall.

// File: rtl/stwc_pkg.sv
package stwc_pkg;
  // default geometry shared by the block, its checker and its bench
  localparam int STWC_ADDR_W     = 32;
  localparam int STWC_LINE_BYTES = 32;
  localparam int STWC_WORD_BYTES = 8;
  localparam int STWC_DEPTH      = 8;
endpackage

// File: rtl/stwc_tagcmp.sv
// Parallel line-number compare against every entry.
module stwc_tagcmp #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 27
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [DEPTH-1:0]            live,
  input  logic [TAG_W-1:0]            key,
  output logic [DEPTH-1:0]            match
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = live[i] && (tags[i] == key);
  end
endmodule

// File: rtl/stwc_fwd.sv
// Load forwarding: combine matching entries oldest to youngest, register result.
module stwc_fwd #(
  parameter int DEPTH      = 8,
  parameter int LINE_BYTES = 32,
  parameter int PTR_W      = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  req,
  input  logic [DEPTH-1:0]                      match,
  input  logic [PTR_W-1:0]                      head,
  input  logic [DEPTH-1:0][LINE_BYTES-1:0]      mask,
  input  logic [DEPTH-1:0][LINE_BYTES-1:0][7:0] data,
  output logic                                  resp_valid,
  output logic [LINE_BYTES-1:0]                 hit,
  output logic [LINE_BYTES-1:0][7:0]            data_o
);
  logic [LINE_BYTES-1:0]      hit_c;
  logic [LINE_BYTES-1:0][7:0] dat_c;

  always_comb begin
    hit_c = '0;
    dat_c = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PTR_W-1:0] idx;
      idx = PTR_W'((int'(head) + i) % DEPTH);
      if (match[idx]) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (mask[idx][b]) begin
            hit_c[b] = 1'b1;
            dat_c[b] = data[idx][b];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      hit        <= '0;
      data_o     <= '0;
    end else begin
      resp_valid <= req;
      hit        <= req ? hit_c : '0;
      data_o     <= req ? dat_c : '0;
    end
  end
endmodule

// File: rtl/stwc_buffer.sv
module stwc_buffer #(
  parameter int ADDR_W     = stwc_pkg::STWC_ADDR_W,
  parameter int LINE_BYTES = stwc_pkg::STWC_LINE_BYTES,
  parameter int WORD_BYTES = stwc_pkg::STWC_WORD_BYTES,
  parameter int DEPTH      = stwc_pkg::STWC_DEPTH
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   st_valid,
  output logic                                   st_ready,
  input  logic [ADDR_W-1:0]                      st_addr,
  input  logic [WORD_BYTES*8-1:0]                st_data,
  input  logic [WORD_BYTES-1:0]                  st_be,
  input  logic                                   ld_valid,
  input  logic [ADDR_W-1:0]                      ld_addr,
  output logic                                   ld_resp_valid,
  output logic [LINE_BYTES-1:0]                  ld_hit,
  output logic [LINE_BYTES*8-1:0]                ld_data,
  output logic                                   dr_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   dr_line,
  output logic [LINE_BYTES*8-1:0]                dr_data,
  output logic [LINE_BYTES-1:0]                  dr_mask,
  input  logic                                   dr_ack
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WB_W   = $clog2(WORD_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int WSEL_W = OFF_W - WB_W;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // entry storage
  logic [DEPTH-1:0][TAG_W-1:0]           e_tag;
  logic [DEPTH-1:0][LINE_BYTES-1:0][7:0] e_data;
  logic [DEPTH-1:0][LINE_BYTES-1:0]      e_mask;
  logic [DEPTH-1:0]                      e_vld;

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  // store decode
  logic [TAG_W-1:0]           st_tag, ld_tag;
  logic [WSEL_W-1:0]          word_sel;
  logic [LINE_BYTES-1:0]      line_be;
  logic [LINE_BYTES-1:0][7:0] line_dat;

  assign st_tag   = st_addr[ADDR_W-1:OFF_W];
  assign ld_tag   = ld_addr[ADDR_W-1:OFF_W];
  assign word_sel = st_addr[OFF_W-1:WB_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{st_addr[WB_W-1:0], ld_addr[OFF_W-1:0]};

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_expand
    assign line_be[b]  = (word_sel == WSEL_W'(b / WORD_BYTES)) && st_be[b % WORD_BYTES];
    assign line_dat[b] = st_data[(b % WORD_BYTES)*8 +: 8];
  end

  // the entry on the drain port is frozen against merging
  logic [DEPTH-1:0] lock;
  logic [DEPTH-1:0] st_match, ld_match;
  assign lock = (count != '0) ? (DEPTH'(1) << head) : '0;

  stwc_tagcmp #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_st_cmp (
    .tags (e_tag),
    .live (e_vld & ~lock),
    .key  (st_tag),
    .match(st_match)
  );

  stwc_tagcmp #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ld_cmp (
    .tags (e_tag),
    .live (e_vld),
    .key  (ld_tag),
    .match(ld_match)
  );

  logic [PTR_W-1:0] merge_idx;
  always_comb begin
    merge_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (st_match[i]) merge_idx = PTR_W'(i);
    end
  end

  logic merge_hit, full, st_fire, alloc, mrg, pop;
  assign merge_hit = |st_match;
  assign full      = (count == CNT_W'(DEPTH));
  assign st_ready  = (st_be == '0) || merge_hit || !full;
  assign st_fire   = st_valid && st_ready;
  assign alloc     = st_fire && !merge_hit && (st_be != '0);
  assign mrg       = st_fire && merge_hit;
  assign pop       = dr_ack && (count != '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop) begin
        e_vld[head] <= 1'b0;
        head        <= bump(head);
      end
      if (alloc) begin
        e_vld[tail] <= 1'b1;
        tail        <= bump(tail);
      end
      count <= count + CNT_W'(alloc) - CNT_W'(pop);
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (alloc) begin
      e_tag[tail] <= st_tag;
      for (int b = 0; b < LINE_BYTES; b++) begin
        e_mask[tail][b] <= line_be[b];
        e_data[tail][b] <= line_be[b] ? line_dat[b] : 8'h00;
      end
    end
    if (mrg) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (line_be[b]) begin
          e_mask[merge_idx][b] <= 1'b1;
          e_data[merge_idx][b] <= line_dat[b];
        end
      end
    end
  end

  // drain port
  assign dr_valid = (count != '0);
  assign dr_line  = e_tag[head];
  assign dr_data  = e_data[head];
  assign dr_mask  = e_mask[head];

  // load forwarding
  logic [LINE_BYTES-1:0][7:0] fwd_data;

  stwc_fwd #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .PTR_W(PTR_W)) u_fwd (
    .clk       (clk),
    .rst       (rst),
    .req       (ld_valid),
    .match     (ld_match),
    .head      (head),
    .mask      (e_mask),
    .data      (e_data),
    .resp_valid(ld_resp_valid),
    .hit       (ld_hit),
    .data_o    (fwd_data)
  );

  assign ld_data = fwd_data;
endmodule

// File: rtl/stwc_buffer_chk.sv
module stwc_buffer_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 8,
  parameter int DEPTH      = 8
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 st_valid,
  input logic                                 st_ready,
  input logic [WORD_BYTES-1:0]                st_be,
  input logic                                 ld_valid,
  input logic                                 ld_resp_valid,
  input logic [LINE_BYTES-1:0]                ld_hit,
  input logic                                 dr_valid,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0] dr_line,
  input logic [LINE_BYTES*8-1:0]              dr_data,
  input logic [LINE_BYTES-1:0]                dr_mask,
  input logic                                 dr_ack,
  input logic [$clog2(DEPTH+1)-1:0]           count
);
  // R5: an unacknowledged drain offer stays put
  p_drain_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dr_valid && !dr_ack) |=> (dr_valid && $stable(dr_line) && $stable(dr_data) && $stable(dr_mask)));

  // R7: refusal only when every entry is taken
  p_stall_only_full_r7: assert property (@(posedge clk) disable iff (rst)
    !st_ready |-> (count == DEPTH));

  // R7: occupancy bounded by depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH);

  // R1: a taken store with enabled bytes leaves something to drain
  p_store_visible_r1: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready && (st_be != '0)) |=> dr_valid);

  // R4: an offered entry always carries written bytes
  p_mask_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    dr_valid |-> (dr_mask != '0));

  // R8: lookup answers one cycle later, silent otherwise
  p_lookup_resp_r8: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> ld_resp_valid);
  p_lookup_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> (!ld_resp_valid && (ld_hit == '0)));
endmodule

bind stwc_buffer stwc_buffer_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/stwc_buffer_tb.sv
module stwc_buffer_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [31:0]  st_addr = '0;
  logic [63:0]  st_data = '0;
  logic [7:0]   st_be = '0;
  logic         ld_valid = 1'b0;
  logic [31:0]  ld_addr = '0;
  logic         ld_resp_valid;
  logic [31:0]  ld_hit;
  logic [255:0] ld_data;
  logic         dr_valid;
  logic [26:0]  dr_line;
  logic [255:0] dr_data;
  logic [31:0]  dr_mask;
  logic         dr_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  stwc_buffer u_dut (.*);

  task automatic expect_eq(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected line image of one store (per R1)
  task automatic mk(input int w, input logic [63:0] d, input logic [7:0] be,
                    output logic [31:0] m, output logic [255:0] dl);
    m = '0; dl = '0;
    for (int j = 0; j < 8; j++) begin
      if (be[j]) begin
        m[w*8+j] = 1'b1;
        dl[(w*8+j)*8 +: 8] = d[j*8 +: 8];
      end
    end
  endtask

  // younger bytes overwrite older (R2, R3)
  task automatic ovl(inout logic [31:0] m, inout logic [255:0] dl,
                     input logic [31:0] nm, input logic [255:0] nd);
    for (int b = 0; b < 32; b++) begin
      if (nm[b]) dl[b*8 +: 8] = nd[b*8 +: 8];
    end
    m = m | nm;
  endtask

  function automatic logic [31:0] addr_of(input int line, input int w);
    return {line[26:0], w[1:0], 3'b000};
  endfunction

  task automatic stor(input int line, input int w, input logic [63:0] d, input logic [7:0] be);
    st_valid = 1'b1; st_addr = addr_of(line, w); st_data = d; st_be = be;
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic lookup(input int line, output logic [31:0] h, output logic [255:0] d, output logic rv);
    ld_valid = 1'b1; ld_addr = addr_of(line, 0) | 32'h1d;
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    h = ld_hit; d = ld_data; rv = ld_resp_valid;
  endtask

  task automatic drain_check(input string tag, input int line, input logic [31:0] m, input logic [255:0] d);
    expect_eq({tag, " dr_valid"}, 256'(dr_valid), 256'(1));
    expect_eq({tag, " dr_line"}, 256'(dr_line), 256'(line));
    expect_eq({tag, " dr_mask"}, 256'(dr_mask), 256'(m));
    expect_eq({tag, " dr_data"}, dr_data, d);
  endtask

  task automatic ack_one();
    dr_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    dr_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] h; logic [255:0] d; logic rv;
    expect_eq("R9 st_ready", 256'(st_ready), 256'(1));
    expect_eq("R9 dr_valid", 256'(dr_valid), 256'(0));
    lookup(5, h, d, rv);
    expect_eq("R9 lookup hit", 256'(h), 256'(0));
    expect_eq("R8 resp_valid", 256'(rv), 256'(1));
  endtask

  task automatic t_single();
    logic [31:0] h, m; logic [255:0] d, ed; logic rv;
    stor(11, 2, 64'hdead_beef_0000_1111, 8'h00);
    expect_eq("R1 zero-enable store ignored", 256'(dr_valid), 256'(0));
    stor(10, 1, 64'h1122_3344_5566_7788, 8'h0f);
    mk(1, 64'h1122_3344_5566_7788, 8'h0f, m, ed);
    drain_check("R1 R4 single", 10, m, ed);
    lookup(10, h, d, rv);
    expect_eq("R8 single hit", 256'(h), 256'(m));
    expect_eq("R8 single data", d, ed);
    lookup(12, h, d, rv);
    expect_eq("R8 other line miss", 256'(h), 256'(0));
    ack_one();
    expect_eq("R5 empty after ack", 256'(dr_valid), 256'(0));
  endtask

  task automatic t_merge();
    logic [31:0] h, m20, m21, m2b, tm; logic [255:0] d, d20, d21, d2b, td, f20; logic rv;
    logic [31:0] fm;
    stor(20, 0, 64'ha0a1_a2a3_a4a5_a6a7, 8'hff);
    mk(0, 64'ha0a1_a2a3_a4a5_a6a7, 8'hff, m20, d20);
    stor(21, 0, 64'h1111_1111_1111_1111, 8'hff);
    mk(0, 64'h1111_1111_1111_1111, 8'hff, m21, d21);
    stor(21, 0, 64'h2222_2222_2222_2222, 8'h0f);
    mk(0, 64'h2222_2222_2222_2222, 8'h0f, tm, td); ovl(m21, d21, tm, td);
    stor(21, 2, 64'h3333_3333_3333_3333, 8'h80);
    mk(2, 64'h3333_3333_3333_3333, 8'h80, tm, td); ovl(m21, d21, tm, td);
    // R6: same line as the entry on the drain port
    stor(20, 0, 64'h0000_0000_0000_00c5, 8'h01);
    mk(0, 64'h0000_0000_0000_00c5, 8'h01, m2b, d2b);
    lookup(21, h, d, rv);
    expect_eq("R2 merged mask", 256'(h), 256'(m21));
    expect_eq("R3 merged data", d, d21);
    fm = m20; f20 = d20; ovl(fm, f20, m2b, d2b);
    lookup(20, h, d, rv);
    expect_eq("R3 cross-entry hit", 256'(h), 256'(fm));
    expect_eq("R3 cross-entry youngest", d, f20);
    drain_check("R6 head untouched", 20, m20, d20);
    repeat (5) @(negedge clk);
    drain_check("R5 hold without ack", 20, m20, d20);
    ack_one();
    drain_check("R4 second in order", 21, m21, d21);
    ack_one();
    drain_check("R6 new entry", 20, m2b, d2b);
    ack_one();
    expect_eq("R5 drained", 256'(dr_valid), 256'(0));
  endtask

  task automatic t_full();
    logic [31:0] m, tm; logic [255:0] dl, td;
    for (int i = 0; i < 8; i++) stor(40 + i, 3, 64'(40 + i), 8'hff);
    st_valid = 1'b1; st_addr = addr_of(48, 0); st_data = 64'h48; st_be = 8'hff;
    #1;
    expect_eq("R7 refused when full", 256'(st_ready), 256'(0));
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    st_addr = addr_of(41, 0); st_data = 64'h4141; #1;
    expect_eq("R7 merge accepted when full", 256'(st_ready), 256'(1));
    st_addr = addr_of(40, 0); #1;
    expect_eq("R7 locked line refused when full", 256'(st_ready), 256'(0));
    st_addr = addr_of(41, 0);
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0;
    mk(3, 64'(40), 8'hff, m, dl);
    drain_check("R4 full head", 40, m, dl);
    ack_one();
    expect_eq("R7 ready after release", 256'(st_ready), 256'(1));
    stor(48, 0, 64'h48, 8'hff);
    for (int i = 1; i < 8; i++) begin
      mk(3, 64'(40 + i), 8'hff, m, dl);
      if (i == 1) begin
        mk(0, 64'h4141, 8'hff, tm, td); ovl(m, dl, tm, td);
      end
      drain_check("R4 order", 40 + i, m, dl);
      ack_one();
    end
    mk(0, 64'h48, 8'hff, m, dl);
    drain_check("R7 stalled store entered once", 48, m, dl);
    ack_one();
    expect_eq("R5 empty at end", 256'(dr_valid), 256'(0));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_merge();
    t_full();
    summary();
    $finish;
  end
endmodule